// File: doc/BRIEF.md
# Multi-core cache purge sequencer

This controller empties the second- and third-level caches of every enabled processor core while a device attached to those cores is being reset. Cache lines that belonged to the device can otherwise stay in the cores after its owner goes away. The first level is write-through, so it never holds dirty data and is left alone.

A single `start` pulse captures a per-thread enable mask. Threads map onto cores in fixed groups. The sequencer then reaches each core's two purge control registers through a simple register bus that has a request, an acknowledge and an error qualifier.

The work runs in two passes. The first pass launches the flush on every selected core and does not wait on any of them. The second pass returns to the cores in the same order and polls each register until the flush is reported finished. Each poll gets its own deadline, measured on a free-running timebase. The outcome is reported through a one-cycle `done` pulse, sticky `error` and `timeout` flags, and the index of the core that failed.

Top module: `cache_purge_seq`

## Requirements
- R1: While reset is held, and right after it, `done`, `error`, `timeout` and `bus_req` are low.
- R2: In the launch pass, each selected core receives four masked writes in ascending core order. The address is `{core, sel}`, where sel 0 is the level-2 register and sel 1 is the level-3 register. The writes are: level-2 type field (data 0x00 meaning full flush, mask 0x1E for bits 4:1), level-2 trigger (data 0x01, mask 0x01 for bit 0), level-3 type field (data 0x00, mask 0x1E), level-3 request (data 0x01, mask 0x01).
- R3: No read is issued until every launch write of the run has completed.
- R4: In the polling pass, cores are visited in the same order. For each core, the level-2 register is read until its busy flag (bit 6) is 0. The level-3 register is then read until its request flag (bit 0) is 0.
- R5: Once level-2 busy is clear, the value just read is written back to the level-2 register with bit 0 cleared and mask 0xFF.
- R6: Thread slot s belongs to core s / THREADS_PER_CORE. Disabled slots are passed over. A slot whose core equals the core handled last in the same pass is also passed over, so each core is handled once per pass.
- R7: If a poll still reads its flag set after more than TICKS_PER_MS*DEADLINE_MS timebase ticks since that poll began, the run stops. `timeout` is set, `fail_core` names the core, `done` pulses, and no further bus request follows.
- R8: Elapsed time is computed modulo 2^TB_W, so a timebase wrap during a poll causes no false timeout.
- R9: An acknowledge with `bus_err` high, on a read or a write, stops the run. `error` is set, `fail_core` names the core being handled, `done` pulses, and `error` and `timeout` are never both set.
- R10: `done` is high for exactly one cycle per run. `error` and `timeout` hold until the next accepted start, which clears them.
- R11: A start pulse that arrives while a run is active is ignored, including the mask that comes with it.
- R12: Once raised, `bus_req` stays high with stable address, direction and data until an acknowledge arrives.
- R13: An all-zero mask finishes with a `done` pulse and no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a purge run (accepted when idle) |
| slot_en | input | SLOTS | Per-thread enable mask, captured at start |
| timebase | input | TB_W | Free-running tick counter |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | CORE_W+1 | `{core, sel}` register address |
| bus_wdata | output | REG_W | Write data |
| bus_wmask | output | REG_W | Bits of the register the write may change |
| bus_ack | input | 1 | Transaction complete |
| bus_err | input | 1 | Qualifies `bus_ack` as a failed transaction |
| bus_rdata | input | REG_W | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run stopped by a bus error |
| timeout | output | 1 | Run stopped by a poll deadline |
| fail_core | output | CORE_W | Core being handled when the run stopped |

## Verification
The hardest situations to reach are the stops that happen in the middle of the polling pass: a level-3 poll that never finishes on a late core, and a bus error on a read rather than a write. A responding register model in the bench holds per-core flush latencies, where "never" is one of the allowed values. The same model can flag an error on the first transaction that matches a chosen direction and address. With these knobs the stop can be placed on exactly one core in exactly one poll.

A second hard case is a timebase wrap that falls inside an active poll. The bench adds an offset to its tick counter so that the wrap lands in the single level-2 poll of a one-core run.

// File: rtl/cache_purge_seq.sv
module cache_purge_seq #(
  parameter int SLOTS            = 8,
  parameter int THREADS_PER_CORE = 2,
  parameter int REG_W            = 8,
  parameter int TB_W             = 32,
  parameter int TICKS_PER_MS     = 1000,
  parameter int DEADLINE_MS      = 2,
  localparam int CORES  = SLOTS / THREADS_PER_CORE,
  localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int ADDR_W = CORE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOTS-1:0]  slot_en,
  input  logic [TB_W-1:0]   timebase,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_wmask,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [REG_W-1:0]  bus_rdata,
  output logic              done,
  output logic              error,
  output logic              timeout,
  output logic [CORE_W-1:0] fail_core
);

  localparam int IDX_W = $clog2(SLOTS + 1);
  localparam int TRIG  = 0;
  localparam int BUSY  = 6;
  localparam logic [REG_W-1:0] TRIG_BIT   = REG_W'(1);
  localparam logic [REG_W-1:0] TYPE_MASK  = REG_W'(30);
  localparam logic [REG_W-1:0] FULL_FLUSH = '0;
  localparam logic [TB_W-1:0]  LIMIT      = TB_W'(TICKS_PER_MS * DEADLINE_MS);

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN,
    S_L2_TYPE, S_L2_TRIG, S_L3_TYPE, S_L3_REQ,
    S_L2_POLL, S_L2_CLR, S_L3_POLL
  } st_t;

  st_t               state;
  logic              phase2;
  logic [IDX_W-1:0]  idx;
  logic [SLOTS-1:0]  en_q;
  logic [CORE_W-1:0] cur_core, prev_core;
  logic              prev_ok;
  logic [TB_W-1:0]   t0;
  logic [REG_W-1:0]  wb;

  logic [CORE_W-1:0] slot_core;
  logic              idx_end, slot_on, fresh, rsp, late, sel;
  logic [TB_W-1:0]   elapsed;

  assign slot_core = CORE_W'(idx / IDX_W'(THREADS_PER_CORE));
  assign idx_end   = (idx == IDX_W'(SLOTS));
  assign slot_on   = !idx_end && |(en_q & (SLOTS'(1) << idx));
  assign fresh     = !(prev_ok && slot_core == prev_core);
  assign elapsed   = timebase - t0;
  assign late      = elapsed > LIMIT;
  assign rsp       = bus_req && bus_ack;
  assign sel       = (state == S_L3_TYPE) || (state == S_L3_REQ) || (state == S_L3_POLL);
  assign bus_addr  = {cur_core, sel};

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b1;
    bus_wdata = '0;
    bus_wmask = '0;
    case (state)
      S_L2_TYPE, S_L3_TYPE: begin bus_wdata = FULL_FLUSH; bus_wmask = TYPE_MASK; end
      S_L2_TRIG, S_L3_REQ:  begin bus_wdata = TRIG_BIT;   bus_wmask = TRIG_BIT;  end
      S_L2_CLR:             begin bus_wdata = wb & ~TRIG_BIT; bus_wmask = '1;    end
      S_L2_POLL, S_L3_POLL: bus_we = 1'b0;
      default: begin bus_req = 1'b0; bus_we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase2    <= 1'b0;
      idx       <= '0;
      en_q      <= '0;
      cur_core  <= '0;
      prev_core <= '0;
      prev_ok   <= 1'b0;
      t0        <= '0;
      wb        <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      timeout   <= 1'b0;
      fail_core <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          en_q      <= slot_en;
          idx       <= '0;
          phase2    <= 1'b0;
          prev_ok   <= 1'b0;
          error     <= 1'b0;
          timeout   <= 1'b0;
          fail_core <= '0;
          state     <= S_SCAN;
        end
        S_SCAN: begin
          if (idx_end) begin
            if (!phase2) begin
              phase2  <= 1'b1;
              idx     <= '0;
              prev_ok <= 1'b0;
            end else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end else if (slot_on && fresh) begin
            prev_core <= slot_core;
            prev_ok   <= 1'b1;
            cur_core  <= slot_core;
            t0        <= timebase;
            state     <= phase2 ? S_L2_POLL : S_L2_TYPE;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: if (rsp) begin
          if (bus_err) begin
            error     <= 1'b1;
            fail_core <= cur_core;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            case (state)
              S_L2_TYPE: state <= S_L2_TRIG;
              S_L2_TRIG: state <= S_L3_TYPE;
              S_L3_TYPE: state <= S_L3_REQ;
              S_L3_REQ: begin
                idx   <= idx + IDX_W'(1);
                state <= S_SCAN;
              end
              S_L2_POLL: begin
                if (bus_rdata[BUSY]) begin
                  if (late) begin
                    timeout   <= 1'b1;
                    fail_core <= cur_core;
                    done      <= 1'b1;
                    state     <= S_IDLE;
                  end
                end else begin
                  wb    <= bus_rdata;
                  state <= S_L2_CLR;
                end
              end
              S_L2_CLR: begin
                t0    <= timebase;
                state <= S_L3_POLL;
              end
              S_L3_POLL: begin
                if (bus_rdata[TRIG]) begin
                  if (late) begin
                    timeout   <= 1'b1;
                    fail_core <= cur_core;
                    done      <= 1'b1;
                    state     <= S_IDLE;
                  end
                end else begin
                  idx   <= idx + IDX_W'(1);
                  state <= S_SCAN;
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) error && !start |=> error);

  // R3
  read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_req && !bus_we |-> phase2);

  // R5
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_wmask == '1) |-> !bus_wdata[TRIG]);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(error && timeout));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !bus_req);

endmodule

// File: tb/cache_purge_seq_bench.sv
module cache_purge_seq_bench;
  localparam int CORES = 4;

  typedef struct packed {
    logic       ph;
    logic       clr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] mask;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  slot_en = '0;
  logic [31:0] tb_cnt = '0;
  logic [31:0] tb_off = '0;
  logic [31:0] timebase;
  logic        bus_req, bus_we, bus_ack, bus_err;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_wmask, bus_rdata;
  logic        done, error, timeout;
  logic [1:0]  fail_core;

  assign timebase = tb_cnt + tb_off;

  always #2 clk = ~clk;
  always @(posedge clk) tb_cnt <= tb_cnt + 1;

  cache_purge_seq #(.SLOTS(8), .THREADS_PER_CORE(2), .REG_W(8), .TB_W(32),
                    .TICKS_PER_MS(10), .DEADLINE_MS(2)) u_cache_purge_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_en(slot_en), .timebase(timebase),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wmask(bus_wmask), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .done(done), .error(error), .timeout(timeout), .fail_core(fail_core));

  item_t exp_q[$];
  int    case_seq = 0;
  int    n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
  int    lat2[CORES], lat3[CORES];
  bit    err_on, err_we;
  logic [2:0] err_addr;

  function automatic logic [7:0] spare(int c);
    return {c[0], 1'b0, c[1], 5'b0};
  endfunction

  // responding register model and scoreboard monitor
  int         seen_seq, rd_ptr, ci;
  bit         fired, sl, bad;
  logic [7:0] old_v, nw_v;
  logic [7:0] l2r[CORES], l3r[CORES];
  int         c2[CORES], c3[CORES];

  always @(posedge clk) begin
    if (!rst_n || case_seq != seen_seq) begin
      seen_seq = case_seq;
      rd_ptr = 0;
      fired = 0;
      for (int c = 0; c < CORES; c++) begin
        l2r[c] = spare(c); l3r[c] = spare(c); c2[c] = 0; c3[c] = 0;
      end
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      bus_rdata <= '0;
    end else begin
      for (int c = 0; c < CORES; c++) begin
        if (c2[c] > 0) begin c2[c]--; if (c2[c] == 0) l2r[c][6] = 1'b0; end
        if (c3[c] > 0) begin c3[c]--; if (c3[c] == 0) l3r[c][0] = 1'b0; end
      end
      if (bus_req && !bus_ack) begin
        ci = int'(bus_addr[2:1]);
        sl = bus_addr[0];
        bad = err_on && !fired && (bus_we == err_we) && (bus_addr == err_addr);
        if (bad) fired = 1;
        m_chk++;
        if (bus_we) begin
          if (rd_ptr >= exp_q.size()) begin
            m_err++;
            $display("FAIL R2: unexpected write actual addr=%0h data=%0h mask=%0h expected none",
                     bus_addr, bus_wdata, bus_wmask);
          end else if (exp_q[rd_ptr].addr !== bus_addr || exp_q[rd_ptr].data !== bus_wdata ||
                       exp_q[rd_ptr].mask !== bus_wmask) begin
            m_err++;
            $display("FAIL %s: write %0d actual addr=%0h data=%0h mask=%0h expected addr=%0h data=%0h mask=%0h",
                     exp_q[rd_ptr].clr ? "R5" : "R2", rd_ptr, bus_addr, bus_wdata, bus_wmask,
                     exp_q[rd_ptr].addr, exp_q[rd_ptr].data, exp_q[rd_ptr].mask);
          end
          rd_ptr++;
          if (!bad) begin
            old_v = sl ? l3r[ci] : l2r[ci];
            nw_v = (old_v & ~bus_wmask) | (bus_wdata & bus_wmask);
            if (!sl) begin
              if (!old_v[0] && nw_v[0]) begin nw_v[6] = 1'b1; c2[ci] = lat2[ci]; end
              l2r[ci] = nw_v;
            end else begin
              if (!old_v[0] && nw_v[0]) c3[ci] = lat3[ci];
              l3r[ci] = nw_v;
            end
          end
        end else begin
          if (rd_ptr < exp_q.size() && exp_q[rd_ptr].ph == 1'b0) begin
            m_err++;
            $display("FAIL R3: read actual addr=%0h before launch write %0d expected no read", bus_addr, rd_ptr);
          end else if (!sl && rd_ptr < exp_q.size() && exp_q[rd_ptr].addr !== bus_addr) begin
            m_err++;
            $display("FAIL R4: level-2 poll actual addr=%0h expected addr=%0h", bus_addr, exp_q[rd_ptr].addr);
          end else if (sl && rd_ptr > 0 && int'(exp_q[rd_ptr-1].addr[2:1]) != ci) begin
            m_err++;
            $display("FAIL R4: level-3 poll actual core=%0d expected core=%0d", ci, exp_q[rd_ptr-1].addr[2:1]);
          end
          bus_rdata <= sl ? l3r[ci] : l2r[ci];
        end
        bus_ack <= 1'b1;
        bus_err <= bad;
      end else begin
        bus_ack <= 1'b0;
        bus_err <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    lat2 = '{3, 12, 20, 30};
    lat3 = '{4, 8, 25, 35};
    err_on = 0; err_we = 0; err_addr = '0;
    tb_off = '0;
  endtask

  task automatic new_case();
    case_seq++;
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic push_w(input bit ph, input bit clr, input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
    item_t it;
    it.ph = ph; it.clr = clr; it.addr = a; it.data = d; it.mask = m;
    exp_q.push_back(it);
  endtask

  task automatic push_p1(input int c);
    push_w(0, 0, {c[1:0], 1'b0}, 8'h00, 8'h1E);
    push_w(0, 0, {c[1:0], 1'b0}, 8'h01, 8'h01);
    push_w(0, 0, {c[1:0], 1'b1}, 8'h00, 8'h1E);
    push_w(0, 0, {c[1:0], 1'b1}, 8'h01, 8'h01);
  endtask

  task automatic push_clr(input int c);
    push_w(1, 1, {c[1:0], 1'b0}, spare(c), 8'hFF);
  endtask

  task automatic run(input string req, input logic [7:0] mask, input bit mid,
                     input bit exp_err, input bit exp_to, input int exp_fail);
    bit got = 0;
    bit stray = 0;
    @(negedge clk);
    slot_en = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (done) got = 1;
      else begin
        if (mid && i == 6) begin start = 1'b1; slot_en = 8'h00; end
        else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(req, "done pulse seen", got, 1);
    @(negedge clk);
    chk("R10", "done lasts one cycle", done, 0);
    chk(exp_err ? "R9" : req, "error flag", error, exp_err);
    chk(exp_to ? "R7" : req, "timeout flag", timeout, exp_to);
    if (exp_err || exp_to) chk(exp_err ? "R9" : "R7", "fail_core", fail_core, exp_fail);
    chk(req, "expected writes all seen", rd_ptr, exp_q.size());
    for (int i = 0; i < 10; i++) begin
      if (bus_req) stray = 1;
      @(negedge clk);
    end
    chk(exp_err ? "R9" : "R7", "no request after done", stray, 0);
    chk("R10", "flags held after done", {error, timeout}, {exp_err, exp_to});
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "error in reset", error, 0);
    chk("R1", "timeout in reset", timeout, 0);
    chk("R1", "bus_req in reset", bus_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus_req after reset", bus_req, 0);

    // R2 R4 R5: every slot enabled, four cores
    new_case();
    for (int c = 0; c < CORES; c++) push_p1(c);
    for (int c = 0; c < CORES; c++) push_clr(c);
    run("R2", 8'hFF, 0, 0, 0, 0);

    // R6: slots 0,4,5 -> cores 0,2,2 -> cores 0 and 2 once each
    new_case();
    push_p1(0); push_p1(2); push_clr(0); push_clr(2);
    run("R6", 8'b0011_0001, 0, 0, 0, 0);

    // R6: slots 1,7 -> cores 0,3
    new_case();
    push_p1(0); push_p1(3); push_clr(0); push_clr(3);
    run("R6", 8'b1000_0010, 0, 0, 0, 0);

    // R13: empty mask
    new_case();
    run("R13", 8'h00, 0, 0, 0, 0);

    // R7: level-2 of core 1 never finishes
    new_case();
    lat2[1] = -1;
    for (int c = 0; c < CORES; c++) push_p1(c);
    push_clr(0);
    run("R7", 8'hFF, 0, 0, 1, 1);
    defaults();

    // R10: flags cleared by next start
    new_case();
    push_p1(1); push_clr(1);
    run("R10", 8'b0000_0100, 0, 0, 0, 0);

    // R7: level-3 of core 2 never finishes
    new_case();
    lat3[2] = -1;
    for (int c = 0; c < CORES; c++) push_p1(c);
    push_clr(0); push_clr(1); push_clr(2);
    run("R7", 8'hFF, 0, 0, 1, 2);
    defaults();

    // R9: error on write of core 1 level-3 type field
    new_case();
    err_on = 1; err_we = 1; err_addr = 3'b011;
    push_p1(0);
    push_w(0, 0, 3'b010, 8'h00, 8'h1E);
    push_w(0, 0, 3'b010, 8'h01, 8'h01);
    push_w(0, 0, 3'b011, 8'h00, 8'h1E);
    run("R9", 8'hFF, 0, 1, 0, 1);
    defaults();

    // R9: error on level-3 poll read of core 2
    new_case();
    err_on = 1; err_we = 0; err_addr = 3'b101;
    for (int c = 0; c < CORES; c++) push_p1(c);
    push_clr(0); push_clr(1); push_clr(2);
    run("R9", 8'hFF, 0, 1, 0, 2);
    defaults();

    // R10: clean run after error clears flag
    new_case();
    push_p1(3); push_clr(3);
    run("R10", 8'b0100_0000, 0, 0, 0, 0);

    // R11: second start with empty mask mid-run is ignored
    new_case();
    for (int c = 0; c < CORES; c++) push_p1(c);
    for (int c = 0; c < CORES; c++) push_clr(c);
    run("R11", 8'hFF, 1, 0, 0, 0);

    // R8: timebase wraps inside the level-2 poll of core 0
    new_case();
    lat2[0] = 25; lat3[0] = 20;
    tb_off = 32'hFFFF_FFE8 - tb_cnt;
    push_p1(0); push_clr(0);
    run("R8", 8'h01, 0, 0, 0, 0);
    defaults();

    $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err + m_err + 1, n_chk + m_chk + 1);
    $finish;
  end

endmodule